// File: doc/BRIEF.md
# Dual-Write Register File with Hardwired Zero

This block is the architectural integer register file of a two-lane in-order core. It holds a small set of general registers (eight 16-bit entries by default). Each issue slot reads two source operands in the same cycle through four independent combinational read ports. Both writeback lanes can commit on the same rising clock edge.

Index 0 is an architectural zero. It always reads as zero, and any write aimed at it is dropped. A write lane has no separate enable: a lane that has nothing to commit simply presents index 0. A synchronous initialization input clears every other entry on one clock edge. During that edge both write lanes are ignored. There is no write-to-read bypass: a read returns the stored value from before the edge, and any forwarding is left to the pipeline.

Top module: `dual_wr_zero_regfile`

## Requirements
- R1: While rst_ni is low, every entry is cleared asynchronously, so every read port returns 0 while reset is held and after it is released.
- R2: Each of the four read ports (slot 0 operand A/B, slot 1 operand A/B) combinationally returns the stored value of the entry its 3-bit index selects. A read in the cycle of a write to that entry returns the old value, and the new value appears after the edge.
- R3: A read port whose index is 0 returns 0, whatever the write lanes have presented.
- R4: A write lane updates its target entry on every rising edge. A lane whose index is 0 changes nothing.
- R5: The two lanes, when they target different nonzero indices, both update on the same edge.
- R6: When both lanes target the same nonzero index on one edge, lane 1's data is stored.
- R7: When init_i is high at a rising edge, entries 1 through 7 become 0 and both write lanes are ignored on that edge.
- R8: After init_i returns low, writes take effect again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous clear of entries 1..7, overrides writes |
| rd_a0_idx_i | input | 3 | Slot 0 operand A index |
| rd_a0_data_o | output | 16 | Slot 0 operand A value |
| rd_b0_idx_i | input | 3 | Slot 0 operand B index |
| rd_b0_data_o | output | 16 | Slot 0 operand B value |
| rd_a1_idx_i | input | 3 | Slot 1 operand A index |
| rd_a1_data_o | output | 16 | Slot 1 operand A value |
| rd_b1_idx_i | input | 3 | Slot 1 operand B index |
| rd_b1_data_o | output | 16 | Slot 1 operand B value |
| wr0_idx_i | input | 3 | Write lane 0 target index (0 means no write) |
| wr0_data_i | input | 16 | Write lane 0 data |
| wr1_idx_i | input | 3 | Write lane 1 target index (0 means no write) |
| wr1_data_i | input | 16 | Write lane 1 data |

## Verification
The write properties observe a commit only through slot 0's operand A port. They assume that every input carries a known value from reset onward, and that a later check of a written entry reads its index on the cycle right after the edge. The bench changes every input only at the falling clock edge, never leaves an input unknown, and places read-after-write checks on the next cycle. The scoreboard keeps a reference copy of the array and predicts every read port on every cycle, including cycles with index-0 writes, same-index collisions and init raised while writes are active.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_NUM_REGS = 8;
  localparam int RF_DATA_W   = 16;
  localparam int RF_RD_PORTS = 4;
  localparam int RF_WR_LANES = 2;
endpackage

// File: rtl/rf_wr_filter.sv
// Decodes one write lane into per-entry strobes; entry 0 never strobed.
module rf_wr_filter #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_REGS-1:1] sel_o
);
  for (genvar e = 1; e < NUM_REGS; e++) begin : g_dec
    assign sel_o[e] = (idx_i == IDX_W'(e));
  end
endmodule

// File: rtl/rf_array.sv
// Storage for entries 1..NUM_REGS-1; higher lane index wins a collision.
module rf_array #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                init_i,
  input  logic [LANES-1:0][NUM_REGS-1:1]      sel_i,
  input  logic [LANES-1:0][DATA_W-1:0]        data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]     regs_o
);
  assign regs_o[0] = '0;

  for (genvar e = 1; e < NUM_REGS; e++) begin : g_ent
    logic [DATA_W-1:0] q, d;
    logic              we;

    always_comb begin
      d  = q;
      we = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (sel_i[l][e]) begin
          d  = data_i[l];
          we = 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (init_i) q <= '0;
      else if (we)     q <= d;
    end

    assign regs_o[e] = q;
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               data_o
);
  // explicit zero guard independent of array contents
  assign data_o = (idx_i == '0) ? '0 : regs_i[idx_i];
endmodule

// File: rtl/dual_wr_zero_regfile.sv
module dual_wr_zero_regfile
  import rf_pkg::*;
#(
  parameter int NUM_REGS = RF_NUM_REGS,
  parameter int DATA_W   = RF_DATA_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [IDX_W-1:0]  rd_a0_idx_i,
  output logic [DATA_W-1:0] rd_a0_data_o,
  input  logic [IDX_W-1:0]  rd_b0_idx_i,
  output logic [DATA_W-1:0] rd_b0_data_o,
  input  logic [IDX_W-1:0]  rd_a1_idx_i,
  output logic [DATA_W-1:0] rd_a1_data_o,
  input  logic [IDX_W-1:0]  rd_b1_idx_i,
  output logic [DATA_W-1:0] rd_b1_data_o,
  input  logic [IDX_W-1:0]  wr0_idx_i,
  input  logic [DATA_W-1:0] wr0_data_i,
  input  logic [IDX_W-1:0]  wr1_idx_i,
  input  logic [DATA_W-1:0] wr1_data_i
);
  logic [RF_WR_LANES-1:0][IDX_W-1:0]    wr_idx;
  logic [RF_WR_LANES-1:0][DATA_W-1:0]   wr_data;
  logic [RF_WR_LANES-1:0][NUM_REGS-1:1] wr_sel;
  logic [RF_RD_PORTS-1:0][IDX_W-1:0]    rd_idx;
  logic [RF_RD_PORTS-1:0][DATA_W-1:0]   rd_data;
  logic [NUM_REGS-1:0][DATA_W-1:0]      regs;

  assign wr_idx  = {wr1_idx_i, wr0_idx_i};
  assign wr_data = {wr1_data_i, wr0_data_i};
  assign rd_idx  = {rd_b1_idx_i, rd_a1_idx_i, rd_b0_idx_i, rd_a0_idx_i};

  for (genvar l = 0; l < RF_WR_LANES; l++) begin : g_wr
    rf_wr_filter #(.NUM_REGS(NUM_REGS)) u_filt (
      .idx_i (wr_idx[l]),
      .sel_o (wr_sel[l])
    );
  end

  rf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LANES(RF_WR_LANES)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .sel_i  (wr_sel),
    .data_i (wr_data),
    .regs_o (regs)
  );

  for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .idx_i  (rd_idx[p]),
      .regs_i (regs),
      .data_o (rd_data[p])
    );
  end

  assign rd_a0_data_o = rd_data[0];
  assign rd_b0_data_o = rd_data[1];
  assign rd_a1_data_o = rd_data[2];
  assign rd_b1_data_o = rd_data[3];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic [IDX_W-1:0]  rd_a0_idx_i,
  input logic [DATA_W-1:0] rd_a0_data_o,
  input logic [IDX_W-1:0]  rd_b0_idx_i,
  input logic [DATA_W-1:0] rd_b0_data_o,
  input logic [IDX_W-1:0]  rd_a1_idx_i,
  input logic [DATA_W-1:0] rd_a1_data_o,
  input logic [IDX_W-1:0]  rd_b1_idx_i,
  input logic [DATA_W-1:0] rd_b1_data_o,
  input logic [IDX_W-1:0]  wr0_idx_i,
  input logic [DATA_W-1:0] wr0_data_i,
  input logic [IDX_W-1:0]  wr1_idx_i,
  input logic [DATA_W-1:0] wr1_data_i
);
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_a0_data_o == '0 && rd_b1_data_o == '0)); // R1

  AST_ZERO_IDX_A0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a0_idx_i == '0 |-> rd_a0_data_o == '0); // R3
  AST_ZERO_IDX_B1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b1_idx_i == '0 |-> rd_b1_data_o == '0); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && wr0_idx_i == '0 && wr1_idx_i == '0) ##1 $stable(rd_a0_idx_i)
    |-> $stable(rd_a0_data_o)); // R4

  AST_LANE0_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && wr0_idx_i != '0 && wr1_idx_i != wr0_idx_i)
    ##1 (rd_a0_idx_i == $past(wr0_idx_i)) |-> rd_a0_data_o == $past(wr0_data_i)); // R5

  AST_LANE1_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && wr1_idx_i != '0)
    ##1 (rd_a0_idx_i == $past(wr1_idx_i)) |-> rd_a0_data_o == $past(wr1_data_i)); // R6

  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (rd_a0_data_o == '0 && rd_b0_data_o == '0 &&
                rd_a1_data_o == '0 && rd_b1_data_o == '0)); // R7
endmodule

bind dual_wr_zero_regfile rf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_i       (init_i),
  .rd_a0_idx_i  (rd_a0_idx_i),
  .rd_a0_data_o (rd_a0_data_o),
  .rd_b0_idx_i  (rd_b0_idx_i),
  .rd_b0_data_o (rd_b0_data_o),
  .rd_a1_idx_i  (rd_a1_idx_i),
  .rd_a1_data_o (rd_a1_data_o),
  .rd_b1_idx_i  (rd_b1_idx_i),
  .rd_b1_data_o (rd_b1_data_o),
  .wr0_idx_i    (wr0_idx_i),
  .wr0_data_i   (wr0_data_i),
  .wr1_idx_i    (wr1_idx_i),
  .wr1_data_i   (wr1_data_i)
);

// File: tb/tb_dual_wr_zero_regfile.sv
`timescale 1ns/1ps
module tb_dual_wr_zero_regfile;
  localparam int CLK_HALF = 4; // 125 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [2:0]  a0_idx = '0, b0_idx = '0, a1_idx = '0, b1_idx = '0;
  logic [15:0] a0_dat, b0_dat, a1_dat, b1_dat;
  logic [2:0]  w0_idx = '0, w1_idx = '0;
  logic [15:0] w0_dat = '0, w1_dat = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          port;
    logic [2:0]  idx;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] model[8];

  always #CLK_HALF clk = ~clk;

  dual_wr_zero_regfile dut (
    .clk_i (clk), .rst_ni (rst_n), .init_i (init),
    .rd_a0_idx_i (a0_idx), .rd_a0_data_o (a0_dat),
    .rd_b0_idx_i (b0_idx), .rd_b0_data_o (b0_dat),
    .rd_a1_idx_i (a1_idx), .rd_a1_data_o (a1_dat),
    .rd_b1_idx_i (b1_idx), .rd_b1_data_o (b1_dat),
    .wr0_idx_i (w0_idx), .wr0_data_i (w0_dat),
    .wr1_idx_i (w1_idx), .wr1_data_i (w1_dat)
  );

  function automatic logic [15:0] port_val(int p);
    case (p)
      0: return a0_dat;
      1: return b0_dat;
      2: return a1_dat;
      default: return b1_dat;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus at the falling edge, predicts reads
  // from the pre-edge model (no bypass), then commits the model at the edge.
  task automatic cycle(input logic [2:0] ra0, input logic [2:0] rb0,
                       input logic [2:0] ra1, input logic [2:0] rb1,
                       input logic [2:0] wi0, input logic [15:0] wd0,
                       input logic [2:0] wi1, input logic [15:0] wd1,
                       input logic ini, input string tag);
    @(negedge clk);
    a0_idx = ra0; b0_idx = rb0; a1_idx = ra1; b1_idx = rb1;
    w0_idx = wi0; w0_dat = wd0; w1_idx = wi1; w1_dat = wd1; init = ini;
    exp_q.push_back('{0, ra0, (ra0 == 0) ? 16'h0 : model[ra0], tag});
    exp_q.push_back('{1, rb0, (rb0 == 0) ? 16'h0 : model[rb0], tag});
    exp_q.push_back('{2, ra1, (ra1 == 0) ? 16'h0 : model[ra1], tag});
    exp_q.push_back('{3, rb1, (rb1 == 0) ? 16'h0 : model[rb1], tag});
    @(posedge clk);
    if (rst_n) begin
      if (ini) begin
        for (int i = 1; i < 8; i++) model[i] = '0;
      end else begin
        if (wi0 != 0) model[wi0] = wd0;
        if (wi1 != 0) model[wi1] = wd1; // lane 1 overrides lane 0
      end
    end
  endtask

  // Monitor: compares every predicted read before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = exp_q.pop_front();
        act = port_val(it.port);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port=%0d idx=%0d actual=%h expected=%h",
                   it.tag, it.port, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 8; i++) model[i] = '0;

    // R1: reset held, writes presented are lost
    cycle(1, 2, 3, 4, 3'd5, 16'hDEAD, 3'd6, 16'hBEEF, 1'b0, "R1");
    cycle(5, 6, 7, 0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;
    cycle(5, 6, 7, 1, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R1");

    // R2/R5: dual write to distinct entries, same-cycle read sees old value
    cycle(1, 2, 1, 2, 3'd1, 16'h1111, 3'd2, 16'h2222, 1'b0, "R2");
    cycle(1, 2, 2, 1, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R5");

    // fill all entries
    for (int i = 1; i < 8; i += 2)
      cycle(0, 0, 0, 0, 3'(i), 16'(16'hA000 + i),
            3'((i + 1) % 8), 16'(16'hB000 + i), 1'b0, "R5");
    cycle(1, 3, 5, 7, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R5");
    cycle(2, 4, 6, 0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R2");

    // R3/R4: both lanes aim at entry 0
    cycle(0, 0, 0, 0, 3'd0, 16'hFFFF, 3'd0, 16'hFFFF, 1'b0, "R4");
    cycle(0, 1, 2, 3, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R3");
    cycle(4, 5, 6, 7, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R4");

    // R4: lane 0 writes on every edge without enable
    cycle(5, 0, 0, 0, 3'd5, 16'h0505, 3'd0, 16'h0, 1'b0, "R4");
    cycle(5, 0, 0, 0, 3'd5, 16'h5050, 3'd0, 16'h0, 1'b0, "R4");
    cycle(5, 5, 5, 5, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R4");

    // R6: collision on entry 3, lane 1 wins
    cycle(3, 0, 0, 0, 3'd3, 16'hC0C0, 3'd3, 16'hC1C1, 1'b0, "R6");
    cycle(3, 3, 3, 3, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R6");

    // R7: init with active writes
    cycle(1, 2, 3, 4, 3'd6, 16'h6666, 3'd7, 16'h7777, 1'b1, "R7");
    cycle(1, 2, 3, 4, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R7");
    cycle(5, 6, 7, 0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R7");

    // R8: writes resume after init
    cycle(0, 0, 0, 0, 3'd6, 16'h0606, 3'd7, 16'h0707, 1'b0, "R8");
    cycle(6, 7, 6, 7, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R8");

    // mixed pseudo-random traffic, occasional init
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      cycle(lfsr[2:0], lfsr[5:3], lfsr[8:6], lfsr[11:9],
            lfsr[14:12], lfsr[31:16], lfsr[17:15], ~lfsr[15:0],
            (lfsr[23:19] == 5'd0), "R2");
    end

    cycle(0, 0, 0, 0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, "R3");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule